// File: doc/BRIEF.md
# Switch Matrix Row Scanner

This block scans a grid of switches wired as rows and columns, six by six by default. It pulls one row line low and leaves the others released. It reads the pulled-up column lines while that row is selected. A closed switch at the crossing pulls its column low. Each row stays selected for a programmable number of dwell ticks. The tick is a one-cycle enable pulse from a slower timebase, for example one pulse per millisecond, which gives a 32 ms dwell and a 192 ms frame.

After the last row has been read, the block publishes a complete map of the grid with one bit per switch, active low. Several switches pressed at once are therefore all reported. A one-cycle strobe marks the publication. For a host that only needs to handle one key at a time, the block also gives the position of the closed switch as a 6-bit number, with a flag. The flag is raised only when exactly one switch in the frame is closed.

Top module: `kpd_scan_top`

## Requirements
- R1: While reset is high and on leaving it, row 0 is selected (`row_n` = all ones except bit 0), `key_map_n` is all ones, and `frame_vld`, `one_key` and `key_idx` are zero.
- R2: Exactly one bit of `row_n` is low at all times. Bit r low selects row r.
- R3: Rows are visited in the order 0, 1, …, ROWS-1 and then wrap to 0. The selection moves after DWELL tick pulses have been seen on the current row.
- R4: Clock cycles without `tick_en` change neither the selected row nor any output.
- R5: In a published map, bit r*COLS+c holds the level of `col_n[c]` on the final dwell tick of row r, so 0 means the switch at row r, column c is closed.
- R6: `frame_vld` is high for exactly one cycle, the cycle after the final sample of row ROWS-1. Successive strobes are ROWS*DWELL tick pulses apart.
- R7: `key_map_n` changes only in a cycle where `frame_vld` is high, and holds its value between frames even if the switches change.
- R8: `one_key` is high with a published map exactly when that map has a single 0 bit, and `key_idx` then gives the position of that bit (0 to 35).
- R9: When a published map has no 0 bits or more than one, `one_key` is 0 and `key_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Dwell timebase pulse, one cycle wide |
| col_n | input | COLS | Column sense lines, pulled high, low = closed switch on the selected row |
| row_n | output | ROWS | Row select lines, low = selected |
| key_map_n | output | ROWS*COLS | Published switch map, bit r*COLS+c, 0 = closed |
| frame_vld | output | 1 | One-cycle strobe when a new map is published |
| one_key | output | 1 | Published map holds exactly one closed switch |
| key_idx | output | clog2(ROWS*COLS) | Position of the single closed switch, else 0 |

## Verification
The bench keeps the 6x6 grid of the default build but cuts the dwell to 3 tick pulses, so one frame takes 18 ticks. Dozens of frames then fit in a short run, each with its own switch pattern. The tick enable is randomly gated, so the tick counting and the hold behaviour are exercised in cycles both with and without ticks. The switch patterns put single closures at the first and last positions, fill a whole row, close every switch, and mix random patterns of varying density. This covers both outcomes of the one-key flag.

// File: rtl/kpd_pkg.sv
package kpd_pkg;

  // bit position of the switch at row r, column c
  function automatic int key_pos(input int r, input int c, input int ncols);
    return r * ncols + c;
  endfunction

  // row visited after row r in a scan of n rows
  function automatic int next_row(input int r, input int n);
    return (r >= n - 1) ? 0 : r + 1;
  endfunction

endpackage

// File: rtl/kpd_row_seq.sv
module kpd_row_seq
  import kpd_pkg::*;
#(
  parameter int ROWS  = 6,
  parameter int DWELL = 32
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 tick_en,
  output logic [((ROWS > 1) ? $clog2(ROWS) : 1)-1:0] row_idx,
  output logic                                 samp_ev,
  output logic                                 last_ev
);
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int DW = $clog2(DWELL + 1);

  logic [DW-1:0] dwell_cnt;
  logic          dwell_end;

  assign dwell_end = tick_en && (dwell_cnt == DW'(DWELL - 1));
  assign samp_ev   = dwell_end;
  assign last_ev   = dwell_end && (row_idx == RW'(ROWS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      dwell_cnt <= '0;
      row_idx   <= '0;
    end else if (tick_en) begin
      if (dwell_end) begin
        dwell_cnt <= '0;
        row_idx   <= RW'(next_row(int'(row_idx), ROWS));
      end else begin
        dwell_cnt <= dwell_cnt + 1'b1;
      end
    end
  end

  // R3
  row_moves_chk: assert property (@(posedge clk) disable iff (rst)
    samp_ev |=> row_idx != $past(row_idx));

  // R3
  row_range_chk: assert property (@(posedge clk) disable iff (rst)
    int'(row_idx) < ROWS);

  // R4
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick_en |=> $stable(row_idx) && $stable(dwell_cnt));

endmodule

// File: rtl/kpd_frame_acc.sv
module kpd_frame_acc
  import kpd_pkg::*;
#(
  parameter int ROWS = 6,
  parameter int COLS = 6
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 samp_ev,
  input  logic [((ROWS > 1) ? $clog2(ROWS) : 1)-1:0] row_idx,
  input  logic [COLS-1:0]                      col_n,
  output logic [ROWS*COLS-1:0]                 frame_next
);
  localparam int RW   = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int KEYS = ROWS * COLS;

  logic [KEYS-1:0] acc;

  // current row's slice replaced by the live column levels
  always_comb begin
    frame_next = acc;
    for (int r = 0; r < ROWS; r++) begin
      if (row_idx == RW'(r)) frame_next[key_pos(r, 0, COLS) +: COLS] = col_n;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          acc <= '1;
    else if (samp_ev) acc <= frame_next;
  end

  // R5
  acc_load_chk: assert property (@(posedge clk) disable iff (rst)
    samp_ev |=> acc == $past(frame_next));

  // R7
  acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !samp_ev |=> $stable(acc));

endmodule

// File: rtl/kpd_single_enc.sv
module kpd_single_enc #(
  parameter int KEYS = 36
) (
  input  logic [KEYS-1:0]         map_n,
  output logic                    single,
  output logic [$clog2(KEYS)-1:0] idx
);
  localparam int IW = $clog2(KEYS);

  function automatic int count_low(input logic [KEYS-1:0] v);
    int n = 0;
    for (int i = 0; i < KEYS; i++) if (!v[i]) n++;
    return n;
  endfunction

  function automatic int low_pos(input logic [KEYS-1:0] v);
    int p = 0;
    for (int i = 0; i < KEYS; i++) if (!v[i]) p = i;
    return p;
  endfunction

  always_comb begin
    single = (count_low(map_n) == 1);
    idx    = single ? IW'(low_pos(map_n)) : '0;
  end

  // R8
  always_comb begin
    single_bit_chk: assert (!single || !map_n[idx]);
  end

endmodule

// File: rtl/kpd_scan_top.sv
module kpd_scan_top
  import kpd_pkg::*;
#(
  parameter int ROWS  = 6,
  parameter int COLS  = 6,
  parameter int DWELL = 32
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           tick_en,
  input  logic [COLS-1:0]                col_n,
  output logic [ROWS-1:0]                row_n,
  output logic [ROWS*COLS-1:0]           key_map_n,
  output logic                           frame_vld,
  output logic                           one_key,
  output logic [$clog2(ROWS*COLS)-1:0]   key_idx
);
  localparam int RW   = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int KEYS = ROWS * COLS;
  localparam int IW   = $clog2(KEYS);

  logic [RW-1:0]   row_idx;
  logic            samp_ev;
  logic            frame_done;
  logic [KEYS-1:0] frame_next;
  logic            enc_single;
  logic [IW-1:0]   enc_idx;

  kpd_row_seq #(.ROWS(ROWS), .DWELL(DWELL)) u_seq (
    .clk(clk), .rst(rst), .tick_en(tick_en),
    .row_idx(row_idx), .samp_ev(samp_ev), .last_ev(frame_done)
  );

  kpd_frame_acc #(.ROWS(ROWS), .COLS(COLS)) u_acc (
    .clk(clk), .rst(rst), .samp_ev(samp_ev), .row_idx(row_idx),
    .col_n(col_n), .frame_next(frame_next)
  );

  kpd_single_enc #(.KEYS(KEYS)) u_enc (
    .map_n(frame_next), .single(enc_single), .idx(enc_idx)
  );

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign row_n[r] = (row_idx != RW'(r));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      key_map_n <= '1;
      frame_vld <= 1'b0;
      one_key   <= 1'b0;
      key_idx   <= '0;
    end else begin
      frame_vld <= frame_done;
      if (frame_done) begin
        key_map_n <= frame_next;
        one_key   <= enc_single;
        key_idx   <= enc_idx;
      end
    end
  end

  // R2
  one_row_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(~row_n) == 1);

  // R6
  vld_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    frame_vld |=> !frame_vld);

  // R7
  map_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_vld |-> $stable(key_map_n) && $stable(one_key) && $stable(key_idx));

  // R9
  idx_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !one_key |-> key_idx == '0);

  // R8
  flag_match_chk: assert property (@(posedge clk) disable iff (rst)
    one_key |-> !key_map_n[key_idx]);

endmodule

// File: tb/sim_kpd_scan_top.sv
module sim_kpd_scan_top;
  localparam int CLK_NS = 10;
  localparam int ROWS   = 6;
  localparam int COLS   = 6;
  localparam int DWELL  = 3;
  localparam int KEYS   = ROWS * COLS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_en = 1'b0;
  logic [COLS-1:0] col_n;
  logic [ROWS-1:0] row_n;
  logic [KEYS-1:0] key_map_n;
  logic frame_vld, one_key;
  logic [5:0] key_idx;

  logic [KEYS-1:0] pressed = '0;
  logic [KEYS-1:0] prev_map = '1;
  bit   tick_hold = 1'b0;
  bit   done = 1'b0;
  int   total = 0, bad = 0;
  int   exp_row = 0, t_in_row = 0;
  int   ticks_seen = 0, ticks_mark = 0;

  always #(CLK_NS/2) clk = ~clk;

  kpd_scan_top #(.ROWS(ROWS), .COLS(COLS), .DWELL(DWELL)) u0 (
    .clk(clk), .rst(rst), .tick_en(tick_en), .col_n(col_n), .row_n(row_n),
    .key_map_n(key_map_n), .frame_vld(frame_vld), .one_key(one_key), .key_idx(key_idx)
  );

  // switch grid model: a closed switch on a selected row pulls its column low
  always_comb begin
    col_n = '1;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        if (!row_n[r] && pressed[r*COLS + c]) col_n[c] = 1'b0;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int n_pressed(input logic [KEYS-1:0] p);
    int n = 0;
    for (int i = 0; i < KEYS; i++) n += p[i];
    return n;
  endfunction

  function automatic int where(input logic [KEYS-1:0] p);
    for (int i = 0; i < KEYS; i++) if (p[i]) return i;
    return 0;
  endfunction

  always @(negedge clk) begin
    if (tick_hold) tick_en <= 1'b0;
    else           tick_en <= ($urandom % 4) != 0;
  end

  // bench view of the row schedule and tick count
  always @(posedge clk) begin
    if (rst) begin
      exp_row = 0; t_in_row = 0; ticks_seen = 0;
    end else if (tick_en) begin
      ticks_seen++;
      t_in_row++;
      if (t_in_row == DWELL) begin
        t_in_row = 0;
        exp_row = (exp_row + 1) % ROWS;
      end
    end
  end

  logic prev_vld = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      // R2 R3
      chk(row_n == ~(ROWS'(1) << exp_row), "R3 row order", 64'(row_n), 64'(~(ROWS'(1) << exp_row)));
      chk(n_pressed({30'd0, ~row_n}) == 1, "R2 one row low", 64'(row_n), 64'd1);
      if (frame_vld) begin
        // R6
        chk(ticks_seen - ticks_mark == ROWS*DWELL, "R6 frame spacing",
            64'(ticks_seen - ticks_mark), 64'(ROWS*DWELL));
        ticks_mark = ticks_seen;
      end
      // R6
      if (prev_vld) chk(!frame_vld, "R6 single cycle strobe", 64'(frame_vld), 64'd0);
      prev_vld = frame_vld;
    end
  end

  task automatic run_frame(input logic [KEYS-1:0] pat);
    int n;
    bit mid_done;
    pressed = pat;
    mid_done = 1'b0;
    do begin
      @(negedge clk);
      if (!mid_done && !frame_vld && exp_row == ROWS/2) begin
        mid_done = 1'b1;
        // R7: switches already changed, map must still show the old frame
        chk(key_map_n == prev_map, "R7 map held mid-frame", 64'(key_map_n), 64'(prev_map));
      end
    end while (!frame_vld);
    // R5
    chk(key_map_n == ~pat, "R5 map content", 64'(key_map_n), 64'(~pat));
    n = n_pressed(pat);
    // R8 R9
    chk(one_key == (n == 1), (n == 1) ? "R8 one_key flag" : "R9 one_key flag",
        64'(one_key), 64'(n == 1));
    chk(key_idx == ((n == 1) ? 6'(where(pat)) : 6'd0), (n == 1) ? "R8 key index" : "R9 key index",
        64'(key_idx), 64'((n == 1) ? where(pat) : 0));
    prev_map = ~pat;
  endtask

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    // R1
    chk(row_n == ~ROWS'(1), "R1 reset row", 64'(row_n), 64'(~ROWS'(1)));
    chk(key_map_n == '1, "R1 reset map", 64'(key_map_n), 64'hf_ffff_ffff);
    chk({frame_vld, one_key, key_idx} == '0, "R1 reset strobe flag index",
        64'({frame_vld, one_key, key_idx}), 64'd0);
    rst = 1'b0;
    run_frame('0);
    run_frame(KEYS'(1));
    run_frame(KEYS'(1) << (KEYS-1));
    run_frame((KEYS'(1) << 7) | (KEYS'(1) << 30));
    run_frame('1);
    run_frame(KEYS'(6'h3f) << (5*COLS));
    run_frame(KEYS'(1) << 20);

    // R4: stop ticks mid-frame, nothing may move
    pressed = KEYS'(1) << 14;
    repeat (4) @(negedge clk);
    tick_hold = 1'b1;
    @(negedge clk);
    begin
      logic [ROWS-1:0] r0;
      r0 = row_n;
      repeat (20) begin
        @(negedge clk);
        chk(row_n == r0 && !frame_vld && key_map_n == prev_map, "R4 idle without ticks",
            64'(row_n), 64'(r0));
      end
    end
    tick_hold = 1'b0;
    run_frame(KEYS'(1) << 14);

    for (int k = 0; k < 24; k++) begin
      logic [KEYS-1:0] p;
      p = '0;
      if (k % 3 == 0) p = KEYS'(1) << ($urandom % KEYS);
      else
        for (int i = 0; i < KEYS; i++) p[i] = ($urandom % (k % 5 + 2)) == 0;
      run_frame(p);
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule